// File: doc/BRIEF.md
# Microcoded accumulator computer

This block is a complete small computer. Every cycle is governed by one word from a 32-entry microcode store. A single internal bus carries one 16-bit value per cycle. The bus source can be the panel switches, the program counter, the accumulator, the instruction register, the ALU result register, or the word of the internal memory that the address register selects. In the same cycle, any of the address register, program counter, accumulator, instruction register and ALU argument register can load from the bus. The ALU writes its result register from the argument register and the bus. An operator drives the machine with a 2-bit mode knob, a 16-bit switch word and a button. The ready and idle lines tell the operator when the machine is waiting. The program counter and accumulator are brought out as display ports, so that the operator, and the bench, can read the machine's state.

A separate sequencer holds the microaddress, which is the machine's state, and picks the next one. It can take a plain jump, a two-way branch on the button, a two-way branch on a zero accumulator, a jump offset by the knob, or a jump offset by the opcode. The microcode routines are as follows:
- Panel idle (0): waits for the button, then goes to knob decode (1).
- Knob decode: goes to one of four routines:
  - set-PC (2) and set-ACC (3), which each return to idle;
  - deposit, which runs address (4) then write (7) and returns to idle;
  - instruction boundary (5).
- Instruction boundary (5): a button press here goes back to idle. Otherwise the machine runs the fetch: address (6), IR load (8), then dispatch (9).
- Dispatch: goes to microaddress 10 plus the opcode, which is one of HALT (10), JMP (11), JZR (12), ADD (13), SUB (14), LD (15), ST (16) and SKIP (17).
- Helper states:
  - ADD uses 19 and 20, SUB uses 22 and 23, and both finish at ACC write-back (21).
  - LD read is 24 and ST write is 25.
  - The PC-increment pair is result (17) then PC load (18), and it returns to the boundary.
  - Words 26 to 31 go straight to idle.

Top module: `acc_ucomputer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the microaddress is 0, ready and idle are both high, and PC and ACC read 0. Microaddresses 26 to 31 always move to 0 on the next edge.
- R2: At microaddress 0, both ready and idle are high. While the button is low the machine stays there and PC and ACC do not change. Idle is never high without ready.
- R3: Knob 0 with a button press loads PC from switch bits 12:0. Knob 1 loads ACC from all 16 switch bits. In both cases idle returns two edges after the edge that samples the button.
- R4: Knob 2 stores ACC into memory at PC. PC and ACC keep their values, and idle returns three edges after the button edge.
- R5: Knob 3 starts execution at PC. An instruction word holds the opcode in bits 15:13 and the address in bits 12:0. Memory is selected by the low MEM_AW bits of an address.
- R6: HALT (opcode 0) returns to idle with PC still pointing at the HALT word.
- R7: JMP (opcode 1) loads PC with the address field and fetches from there.
- R8: JZR (opcode 2) jumps to the address field when ACC is zero. Otherwise it continues at PC+1.
- R9: ADD (opcode 3) sets ACC to ACC plus memory, and SUB (opcode 4) sets ACC to ACC minus memory, both modulo 2^16. Both then advance PC.
- R10: LD (opcode 5) copies memory into ACC, and ST (opcode 6) copies ACC into memory. Both then advance PC.
- R11: SKIP (opcode 7) only advances PC by one.
- R12: Counting edges after the run button edge: one edge to reach the boundary, then per instruction 4 fetch edges plus HALT 1, JMP 1, JZR-taken 2, JZR-not-taken 3, ADD or SUB 6, LD or ST 4, SKIP 2.
- R13: A button held high while a program runs stops it at the next instruction boundary. The machine returns to idle with PC at the next instruction to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_val | input | 16 | Panel switch word |
| knob | input | 2 | Panel mode knob |
| button | input | 1 | Panel button |
| ready | output | 1 | Waiting at idle or at an instruction boundary |
| idle | output | 1 | Waiting at panel idle |
| pc_show | output | 13 | Program counter display |
| acc_show | output | 16 | Accumulator display |

## Verification
The hardest situation to reach from the ports is the stop request. The button is sampled during a run only in the single boundary cycle, between ordinary multi-cycle instruction routines. The bench therefore loads a one-word self-jump loop through the panel, starts it, and confirms that the machine is still running after many cycles. It then holds the button until idle appears, and drops it on that same half-cycle, before the idle state can act on it again. The zero branch on a wrapped ADD result, and the cycle counts of every routine, are reached by depositing directed programs and constrained random straight-line programs. The bench compares these against its own instruction-level model.

// File: rtl/uc_pkg.sv
package uc_pkg;

    localparam int UA_W = 5;
    localparam int UW_W = 29;
    localparam int OPC_W = 3;

    typedef logic [UW_W-1:0] uword_t;

    typedef enum logic [UA_W-1:0] {
        UA_IDLE = 5'd0, UA_KNOB = 5'd1, UA_SET_PC = 5'd2, UA_SET_ACC = 5'd3,
        UA_DEP_MAR = 5'd4, UA_BOUNDARY = 5'd5, UA_FETCH_MAR = 5'd6, UA_DEP_WR = 5'd7,
        UA_FETCH_IR = 5'd8, UA_DISPATCH = 5'd9, UA_HALT = 5'd10, UA_JMP = 5'd11,
        UA_JZR = 5'd12, UA_ADD_ARG = 5'd13, UA_SUB_ARG = 5'd14, UA_LD_MAR = 5'd15,
        UA_ST_MAR = 5'd16, UA_INC_PC = 5'd17, UA_LOAD_PC = 5'd18, UA_ADD_MAR = 5'd19,
        UA_ADD_OP = 5'd20, UA_TO_ACC = 5'd21, UA_SUB_MAR = 5'd22, UA_SUB_OP = 5'd23,
        UA_LD_RD = 5'd24, UA_ST_WR = 5'd25
    } uaddr_e;

    typedef enum logic [2:0] {
        NX_JUMP = 3'd0, NX_BUTTON = 3'd1, NX_ACCZ = 3'd2, NX_KNOB = 3'd3, NX_OPCODE = 3'd4
    } nxt_e;

    typedef enum logic [1:0] {
        ALU_NONE = 2'b00, ALU_INC = 2'b01, ALU_ADD = 2'b10, ALU_SUB = 2'b11
    } alu_e;

    // Control bits 28 down to 15 of a microword, most significant first.
    typedef struct packed {
        logic src_sw;
        logic mar_ld;
        logic mem_wr;
        logic mem_rd;
        logic pc_ld;
        logic src_pc;
        logic acc_ld;
        logic src_acc;
        logic ir_ld;
        logic src_ir;
        logic arg_ld;
        alu_e alu;
        logic src_res;
    } ctl_t;

    localparam int MB_SW = 28, MB_MAR_LD = 27, MB_WR = 26, MB_RD = 25;
    localparam int MB_PC_LD = 24, MB_SRC_PC = 23, MB_ACC_LD = 22, MB_SRC_ACC = 21;
    localparam int MB_IR_LD = 20, MB_SRC_IR = 19, MB_ARG_LD = 18, MB_ADD = 17;
    localparam int MB_INC = 16, MB_SRC_RES = 15, MB_READY = 14, MB_IDLE = 13;

    function automatic uword_t mb(input int pos);
        return uword_t'(1) << pos;
    endfunction

    // Next-address field: [12:8] default target, [7:3] taken target, [2:0] kind.
    function automatic uword_t nx(input nxt_e kind, input logic [UA_W-1:0] taken,
                                  input logic [UA_W-1:0] other);
        return uword_t'({other, taken, kind});
    endfunction

    function automatic uword_t go(input logic [UA_W-1:0] target);
        return nx(NX_JUMP, '0, target);
    endfunction

endpackage

// File: rtl/uc_rom.sv
module uc_rom
    import uc_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          uword
);

    always_comb begin
        unique case (addr)
            UA_IDLE:      uword = mb(MB_READY) | mb(MB_IDLE) | nx(NX_BUTTON, UA_KNOB, UA_IDLE);
            UA_KNOB:      uword = nx(NX_KNOB, '0, UA_SET_PC);
            UA_SET_PC:    uword = mb(MB_SW) | mb(MB_PC_LD) | go(UA_IDLE);
            UA_SET_ACC:   uword = mb(MB_SW) | mb(MB_ACC_LD) | go(UA_IDLE);
            UA_DEP_MAR:   uword = mb(MB_SRC_PC) | mb(MB_MAR_LD) | go(UA_DEP_WR);
            UA_BOUNDARY:  uword = mb(MB_READY) | nx(NX_BUTTON, UA_IDLE, UA_FETCH_MAR);
            UA_FETCH_MAR: uword = mb(MB_SRC_PC) | mb(MB_MAR_LD) | go(UA_FETCH_IR);
            UA_DEP_WR:    uword = mb(MB_SRC_ACC) | mb(MB_WR) | go(UA_IDLE);
            UA_FETCH_IR:  uword = mb(MB_RD) | mb(MB_IR_LD) | go(UA_DISPATCH);
            UA_DISPATCH:  uword = nx(NX_OPCODE, '0, UA_HALT);
            UA_HALT:      uword = go(UA_IDLE);
            UA_JMP:       uword = mb(MB_SRC_IR) | mb(MB_PC_LD) | go(UA_BOUNDARY);
            UA_JZR:       uword = nx(NX_ACCZ, UA_JMP, UA_INC_PC);
            UA_ADD_ARG:   uword = mb(MB_SRC_ACC) | mb(MB_ARG_LD) | go(UA_ADD_MAR);
            UA_SUB_ARG:   uword = mb(MB_SRC_ACC) | mb(MB_ARG_LD) | go(UA_SUB_MAR);
            UA_LD_MAR:    uword = mb(MB_SRC_IR) | mb(MB_MAR_LD) | go(UA_LD_RD);
            UA_ST_MAR:    uword = mb(MB_SRC_IR) | mb(MB_MAR_LD) | go(UA_ST_WR);
            UA_INC_PC:    uword = mb(MB_SRC_PC) | mb(MB_INC) | go(UA_LOAD_PC);
            UA_LOAD_PC:   uword = mb(MB_SRC_RES) | mb(MB_PC_LD) | go(UA_BOUNDARY);
            UA_ADD_MAR:   uword = mb(MB_SRC_IR) | mb(MB_MAR_LD) | go(UA_ADD_OP);
            UA_ADD_OP:    uword = mb(MB_RD) | mb(MB_ADD) | go(UA_TO_ACC);
            UA_TO_ACC:    uword = mb(MB_SRC_RES) | mb(MB_ACC_LD) | go(UA_INC_PC);
            UA_SUB_MAR:   uword = mb(MB_SRC_IR) | mb(MB_MAR_LD) | go(UA_SUB_OP);
            UA_SUB_OP:    uword = mb(MB_RD) | mb(MB_ADD) | mb(MB_INC) | go(UA_TO_ACC);
            UA_LD_RD:     uword = mb(MB_RD) | mb(MB_ACC_LD) | go(UA_INC_PC);
            UA_ST_WR:     uword = mb(MB_SRC_ACC) | mb(MB_WR) | go(UA_INC_PC);
            default:      uword = go(UA_IDLE);  // words 26..31
        endcase
    end

endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [12:0]      nx_field,
    input  logic             button,
    input  logic             acc_zero,
    input  logic [1:0]       knob,
    input  logic [OPC_W-1:0] opcode,
    output uaddr_e           upc
);

    nxt_e            kind;
    logic [UA_W-1:0] tgt_taken;
    logic [UA_W-1:0] tgt_other;
    logic [UA_W-1:0] upc_next;

    assign kind      = nxt_e'(nx_field[2:0]);
    assign tgt_taken = nx_field[7:3];
    assign tgt_other = nx_field[12:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upc <= UA_IDLE;
        else        upc <= uaddr_e'(upc_next);
    end

    always_comb begin
        unique case (kind)
            NX_BUTTON: upc_next = button   ? tgt_taken : tgt_other;
            NX_ACCZ:   upc_next = acc_zero ? tgt_taken : tgt_other;
            NX_KNOB:   upc_next = tgt_other + UA_W'(knob);
            NX_OPCODE: upc_next = tgt_other + UA_W'(opcode);
            default:   upc_next = tgt_other;
        endcase
    end

endmodule

// File: rtl/uc_datapath.sv
module uc_datapath
    import uc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 13,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] sw_val,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] acc_q,
    output logic [OPC_W-1:0]  opcode,
    output logic              acc_zero
);

    localparam int MEM_DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [MEM_DEPTH];
    logic [MEM_AW-1:0] mar_q;
    logic [DATA_W-1:0] ir_q, arg_q, res_q;
    logic [DATA_W-1:0] bus;

    // One source per microword; no source leaves the bus at zero.
    always_comb begin
        bus = '0;
        if (ctl.src_sw)  bus = bus | sw_val;
        if (ctl.src_pc)  bus = bus | DATA_W'(pc_q);
        if (ctl.src_acc) bus = bus | acc_q;
        if (ctl.src_ir)  bus = bus | ir_q;
        if (ctl.src_res) bus = bus | res_q;
        if (ctl.mem_rd)  bus = bus | mem[mar_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            acc_q <= '0;
            ir_q  <= '0;
            arg_q <= '0;
            res_q <= '0;
        end else begin
            if (ctl.pc_ld)  pc_q  <= bus[ADDR_W-1:0];
            if (ctl.mar_ld) mar_q <= bus[MEM_AW-1:0];
            if (ctl.acc_ld) acc_q <= bus;
            if (ctl.ir_ld)  ir_q  <= bus;
            if (ctl.arg_ld) arg_q <= bus;
            unique case (ctl.alu)
                ALU_ADD:  res_q <= arg_q + bus;
                ALU_INC:  res_q <= bus + DATA_W'(1);
                ALU_SUB:  res_q <= arg_q - bus;
                default:  res_q <= res_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (ctl.mem_wr) mem[mar_q] <= bus;
    end

    assign opcode   = ir_q[DATA_W-1 -: OPC_W];
    assign acc_zero = (acc_q == '0);

endmodule

// File: rtl/acc_ucomputer.sv
module acc_ucomputer
    import uc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 13,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sw_val,
    input  logic [1:0]        knob,
    input  logic              button,
    output logic              ready,
    output logic              idle,
    output logic [ADDR_W-1:0] pc_show,
    output logic [DATA_W-1:0] acc_show
);

    uaddr_e           upc;
    uword_t           uword;
    ctl_t             ctl;
    logic [OPC_W-1:0] opcode;
    logic             acc_zero;

    uc_rom u_rom (
        .addr  (upc),
        .uword (uword)
    );

    assign ctl   = ctl_t'(uword[MB_SW:MB_SRC_RES]);
    assign ready = uword[MB_READY];
    assign idle  = uword[MB_IDLE];

    uc_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .nx_field (uword[12:0]),
        .button   (button),
        .acc_zero (acc_zero),
        .knob     (knob),
        .opcode   (opcode),
        .upc      (upc)
    );

    uc_datapath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .sw_val   (sw_val),
        .pc_q     (pc_show),
        .acc_q    (acc_show),
        .opcode   (opcode),
        .acc_zero (acc_zero)
    );

endmodule

// File: rtl/uc_checker.sv
module uc_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              button,
    input logic [DATA_W-1:0] sw_val,
    input logic              ready,
    input logic              idle,
    input logic [4:0]        upc,
    input logic [ADDR_W-1:0] pc_show,
    input logic [DATA_W-1:0] acc_show
);

    AST_UNUSED_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upc >= 5'd26) |=> (upc == 5'd0)) else $error("unused word did not return"); // R1

    AST_IDLE_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> ready) else $error("idle without ready"); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !button) |=> (idle && $stable(pc_show) && $stable(acc_show)))
        else $error("idle not held"); // R2

    AST_PANEL_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 5'd2) |=> (pc_show == $past(sw_val[ADDR_W-1:0])))
        else $error("panel PC load wrong"); // R3

    AST_PANEL_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 5'd3) |=> (acc_show == $past(sw_val)))
        else $error("panel ACC load wrong"); // R3

    AST_DEPOSIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 5'd7) |=> ($stable(pc_show) && $stable(acc_show) && idle))
        else $error("deposit disturbed registers"); // R4

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 5'd10) |=> (idle && $stable(pc_show)))
        else $error("halt did not stop"); // R6

    AST_BOUNDARY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 5'd5 && button) |=> idle) else $error("stop request ignored"); // R13

endmodule

bind acc_ucomputer uc_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .button   (button),
    .sw_val   (sw_val),
    .ready    (ready),
    .idle     (idle),
    .upc      (upc),
    .pc_show  (pc_show),
    .acc_show (acc_show)
);

// File: tb/acc_ucomputer_tb.sv
`timescale 1ns/1ps
module acc_ucomputer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sw_val = '0;
    logic [1:0]  knob = '0;
    logic        button = 1'b0;
    logic        ready, idle;
    logic [12:0] pc_show;
    logic [15:0] acc_show;

    int checks = 0;
    int fails = 0;
    logic [15:0] bm [256];

    always #2.5 clk = ~clk;

    acc_ucomputer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_val   (sw_val),
        .knob     (knob),
        .button   (button),
        .ready    (ready),
        .idle     (idle),
        .pc_show  (pc_show),
        .acc_show (acc_show)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle(input int limit, output int edges);
        edges = 0;
        do begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end while (!idle && edges < limit);
    endtask

    task automatic panel(input logic [1:0] k, input logic [15:0] v, output int edges);
        knob   = k;
        sw_val = v;
        button = 1'b1;
        @(posedge clk);
        @(negedge clk);
        button = 1'b0;
        wait_idle(5000, edges);
    endtask

    task automatic set_pc(input logic [12:0] a);
        int e;
        panel(2'd0, 16'(a), e);
    endtask

    task automatic set_acc(input logic [15:0] v);
        int e;
        panel(2'd1, v, e);
    endtask

    task automatic deposit(input logic [12:0] a, input logic [15:0] v);
        int e;
        set_pc(a);
        set_acc(v);
        panel(2'd2, 16'h0, e);
        bm[a[7:0]] = v;
    endtask

    function automatic logic [15:0] ins(input int op, input int a);
        return {3'(op), 13'(a)};
    endfunction

    // Instruction-level model: PC, ACC and edge count from the requirements.
    task automatic model(input logic [12:0] start, input logic [15:0] acc0,
                         output logic [12:0] pc, output logic [15:0] acc, output int cyc);
        logic [15:0] w;
        logic [12:0] a;
        pc  = start;
        acc = acc0;
        cyc = 1;
        for (int step = 0; step < 500; step++) begin
            w = bm[pc[7:0]];
            a = w[12:0];
            cyc += 4;
            case (w[15:13])
                3'd0: begin cyc += 1; break; end
                3'd1: begin cyc += 1; pc = a; end
                3'd2: if (acc == 16'h0) begin cyc += 2; pc = a; end
                      else begin cyc += 3; pc = pc + 13'd1; end
                3'd3: begin cyc += 6; acc = acc + bm[a[7:0]]; pc = pc + 13'd1; end
                3'd4: begin cyc += 6; acc = acc - bm[a[7:0]]; pc = pc + 13'd1; end
                3'd5: begin cyc += 4; acc = bm[a[7:0]]; pc = pc + 13'd1; end
                3'd6: begin cyc += 4; bm[a[7:0]] = acc; pc = pc + 13'd1; end
                default: begin cyc += 2; pc = pc + 13'd1; end
            endcase
        end
    endtask

    task automatic check_run(input string req, input logic [12:0] start, input logic [15:0] acc0);
        logic [12:0] epc;
        logic [15:0] eacc;
        int ecyc, edges;
        model(start, acc0, epc, eacc, ecyc);
        set_pc(start);
        set_acc(acc0);
        panel(2'd3, 16'h0, edges);
        chk({req, " pc"}, 32'(pc_show), 32'(epc));
        chk({req, " acc"}, 32'(acc_show), 32'(eacc));
        chk({req, " R12 cycles"}, 32'(edges), 32'(ecyc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int e;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 idle", 32'(idle), 32'd1);
        chk("R1 pc", 32'(pc_show), 32'd0);
        chk("R1 acc", 32'(acc_show), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(idle), 32'd1);

        // R3: panel loads and their timing
        panel(2'd0, 16'hFABC, e);
        chk("R3 pc from switches", 32'(pc_show), 32'h1ABC);
        chk("R3 set-pc edges", 32'(e), 32'd2);
        panel(2'd1, 16'hBEEF, e);
        chk("R3 acc from switches", 32'(acc_show), 32'hBEEF);
        chk("R3 set-acc edges", 32'(e), 32'd2);

        // R2: idle holds while the button is low, whatever the other inputs do
        for (int i = 0; i < 10; i++) begin
            knob   = 2'(i);
            sw_val = 16'($urandom);
            @(negedge clk);
            chk("R2 idle held", 32'({idle, ready}), 32'd3);
        end
        chk("R2 pc kept", 32'(pc_show), 32'h1ABC);
        chk("R2 acc kept", 32'(acc_show), 32'hBEEF);

        // R4: deposit leaves PC and ACC alone
        set_pc(13'd200);
        set_acc(16'h0001);
        panel(2'd2, 16'h5555, e);
        bm[200] = 16'h0001;
        chk("R4 deposit edges", 32'(e), 32'd3);
        chk("R4 pc kept", 32'(pc_show), 32'd200);
        chk("R4 acc kept", 32'(acc_show), 32'h0001);

        // R6 / R12: lone HALT
        deposit(13'd5, ins(0, 0));
        set_pc(13'd5);
        panel(2'd3, 16'h0, e);
        chk("R6 halt pc", 32'(pc_show), 32'd5);
        chk("R12 halt edges", 32'(e), 32'd6);

        // R8: JZR taken and not taken
        deposit(13'd40, ins(2, 43));
        deposit(13'd41, ins(0, 0));
        deposit(13'd43, ins(0, 0));
        check_run("R8 jzr taken", 13'd40, 16'h0000);
        chk("R8 taken target", 32'(pc_show), 32'd43);
        check_run("R8 jzr not taken", 13'd40, 16'h0005);
        chk("R8 fall through", 32'(pc_show), 32'd41);

        // R9: ADD wraps to zero, SUB wraps below zero; R5 address uses low bits
        deposit(13'd50, ins(3, 200));
        deposit(13'd51, ins(0, 0));
        check_run("R9 add wrap", 13'd50, 16'hFFFF);
        chk("R9 add wrap value", 32'(acc_show), 32'h0000);
        deposit(13'd52, ins(4, 13'h1000 + 200));
        deposit(13'd53, ins(0, 0));
        check_run("R9 R5 sub wrap", 13'd52, 16'h0000);
        chk("R9 sub wrap value", 32'(acc_show), 32'hFFFF);

        // R10: ST then LD then ADD
        deposit(13'd212, 16'h0007);
        deposit(13'd60, ins(6, 211));
        deposit(13'd61, ins(5, 212));
        deposit(13'd62, ins(3, 211));
        deposit(13'd63, ins(0, 0));
        check_run("R10 st ld", 13'd60, 16'h0005);
        chk("R10 result", 32'(acc_show), 32'h000C);

        // R11 / R7: SKIP pair, then JMP
        deposit(13'd70, ins(7, 0));
        deposit(13'd71, ins(1, 80));
        deposit(13'd80, ins(7, 0));
        deposit(13'd81, ins(0, 0));
        check_run("R11 R7 skip jmp", 13'd70, 16'h1234);
        chk("R7 landed", 32'(pc_show), 32'd81);

        // R13: stop a self loop at the boundary
        deposit(13'd30, ins(1, 30));
        set_pc(13'd30);
        set_acc(16'h4321);
        knob = 2'd3;
        button = 1'b1;
        @(posedge clk);
        @(negedge clk);
        button = 1'b0;
        repeat (23) @(negedge clk);
        chk("R13 still running", 32'(idle), 32'd0);
        button = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (idle) break;
        end
        button = 1'b0;
        chk("R13 stopped", 32'(idle), 32'd1);
        chk("R13 pc", 32'(pc_show), 32'd30);
        chk("R13 acc", 32'(acc_show), 32'h4321);

        // R5..R12: random forward-only programs
        for (int p = 0; p < 30; p++) begin
            int n;
            n = int'($urandom_range(3, 12));
            for (int d = 0; d < 16; d++) deposit(13'(200 + d), 16'($urandom));
            for (int i = 0; i < n - 1; i++) begin
                int op;
                int a;
                op = int'($urandom_range(1, 7));
                if (op <= 2) a = int'($urandom_range(i + 1, n - 1));
                else         a = 200 + int'($urandom_range(0, 15));
                deposit(13'(i), ins(op, a));
            end
            deposit(13'(n - 1), ins(0, 0));
            check_run("R5 random program", 13'd0, ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule